// File: doc/BRIEF.md
# Key-Sense Interrupt Combiner

This block folds a bank of active-low key-sense inputs, a bank of active-low wake-up inputs and an external interrupt pin into two shared interrupt channels, called channel 6 and channel 7. The lower half of the key bank drives channel 6. The upper half of the key bank, the wake-up bank and the channel-7 pin drive channel 7. Each source has its own mask bit. A masked source is held inactive (high). A channel's line is the AND of its gated sources, so the line goes low as soon as any unmasked source goes low.

The channel-7 pin comes either from a primary pad or from an alternate pad, chosen by a select bit. As long as any upper key mask bit or any wake-up mask bit is clear, the pin is cut off from channel 7. Every external input is synchronised before use. Each channel then has a sense stage with four modes and an enable, and it drives one request output. In the edge modes the request is latched until software clears it. In low-level mode the request tracks the line directly. Software configures the block through a write-only register port.

Top module: `key_irq_combiner`

## Requirements
- R1: After reset, every key mask bit is 1 except bit 6, which is 0. Every wake mask bit is 1. The control register is 0, so both channels are disabled in low-level mode with the primary pin selected. Both request outputs are 0.
- R2: Channel 6 line = AND over k=0..7 of (key_ni[k] OR keymask[k]). A key whose mask bit is 1 has no effect on the request.
- R3: Channel 7 line = AND of (key_ni[k] OR keymask[k]) for k=8..15, AND of (wake_ni[w] OR wakemask[w]) for w=0..7, and the gated pin term.
- R4: The pin term is the selected pin only while keymask[15:8] and wakemask[7:0] are all 1. Otherwise the pin term is 1, so the pin is ignored.
- R5: Control bit 6 selects the pin: 0 selects irq7_pri_ni, 1 selects irq7_alt_ni.
- R6: Every input passes two synchronising flip-flops. In low-level mode, an input change driven before clock edge N shows on the request after edge N+1. In edge modes, it shows after edge N+2.
- R7: Sense field encoding is 00 low level, 01 falling edge, 10 rising edge, 11 both edges. In edge modes a detected edge sets a request flag. The flag stays set until a write to address 3 with data bit 0 set (channel 6) or bit 1 set (channel 7).
- R8: On a channel with no shared source, rising mode (10) and both-edge mode (11) latch the corresponding line transitions. A falling transition in rising mode is ignored.
- R9: A channel is shared when it has a source other than its dedicated pin unmasked. For channel 6 that means any key mask bit 0..7 other than bit 6. For channel 7 it is the R4 cut-off condition. A shared channel raises nothing in modes 10 and 11. Modes 00 and 01 still work on it.
- R10: Control bit 4 enables channel 6 and bit 5 enables channel 7. A disabled channel drives its request low and latches no edges.
- R11: In low-level mode an enabled channel's request equals the inverse of its line, with no latching.
- R12: A clear write whose bit for a channel is 0 leaves that channel's flag unchanged.

Register map: address 0 is the key mask (16 bits). Address 1 is the wake mask (bits 7:0). Address 2 is control: bits 1:0 are the channel-6 sense field, bits 3:2 the channel-7 sense field, then bit 4, bit 5 and bit 6 as above. Address 3 is the clear register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_ni | input | 16 | Key-sense inputs, active low |
| wake_ni | input | 8 | Wake-up inputs, active low |
| irq7_pri_ni | input | 1 | Primary channel-7 pin, active low |
| irq7_alt_ni | input | 1 | Alternate channel-7 pin, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| irq6_req_o | output | 1 | Channel-6 interrupt request |
| irq7_req_o | output | 1 | Channel-7 interrupt request |

## Verification
A corrupted mask or control register shows within two cycles of the next input change as a request that appears or is missing. A pin that leaks through while shared sources are unmasked surfaces on irq7_req_o in that same window. A flag that is lost, or set when it should not be, shows on the very next cycle in an edge mode and then persists until a clear, so a cycle-by-cycle comparison against the bench's model catches it. An edge detector seeded with the wrong history produces a spurious request one cycle after the line settles.

// File: rtl/kic_pkg.sv
package kic_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;

  typedef struct packed {
    logic   pin_alt;
    logic   en7;
    logic   en6;
    sense_e mode7;
    sense_e mode6;
  } ctrl_t;

  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_KEYMASK  = 2'd0;
  localparam logic [ADDR_W-1:0] A_WAKEMASK = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL     = 2'd2;
  localparam logic [ADDR_W-1:0] A_CLEAR    = 2'd3;
endpackage

// File: rtl/kic_sync.sv
module kic_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  // idle level of every source is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '1;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/kic_regs.sv
module kic_regs
  import kic_pkg::*;
#(
  parameter int unsigned N_KEY    = 16,
  parameter int unsigned N_WAKE   = 8,
  parameter int unsigned PIN6_KEY = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_KEY-1:0]  wdata_i,
  output logic [N_KEY-1:0]  key_mask_o,
  output logic [N_WAKE-1:0] wake_mask_o,
  output ctrl_t             ctrl_o,
  output logic              clr6_o,
  output logic              clr7_o
);
  localparam int unsigned CTRL_W = $bits(ctrl_t);
  localparam logic [N_KEY-1:0] KEY_MASK_RST = ~(N_KEY'(1) << PIN6_KEY);

  logic [N_KEY-1:0]  key_mask_q;
  logic [N_WAKE-1:0] wake_mask_q;
  ctrl_t             ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_mask_q  <= KEY_MASK_RST;
      wake_mask_q <= '1;
      ctrl_q      <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        A_KEYMASK:  key_mask_q  <= wdata_i;
        A_WAKEMASK: wake_mask_q <= wdata_i[N_WAKE-1:0];
        A_CTRL:     ctrl_q      <= ctrl_t'(wdata_i[CTRL_W-1:0]);
        default:    ;
      endcase
    end
  end

  assign clr6_o      = we_i && (addr_i == A_CLEAR) && wdata_i[0];
  assign clr7_o      = we_i && (addr_i == A_CLEAR) && wdata_i[1];
  assign key_mask_o  = key_mask_q;
  assign wake_mask_o = wake_mask_q;
  assign ctrl_o      = ctrl_q;
endmodule

// File: rtl/kic_merge.sv
module kic_merge #(
  parameter int unsigned N_KEY    = 16,
  parameter int unsigned N_WAKE   = 8,
  parameter int unsigned PIN6_KEY = 6
) (
  input  logic [N_KEY-1:0]  key_s_i,
  input  logic [N_WAKE-1:0] wake_s_i,
  input  logic              pin_pri_s_i,
  input  logic              pin_alt_s_i,
  input  logic [N_KEY-1:0]  key_mask_i,
  input  logic [N_WAKE-1:0] wake_mask_i,
  input  logic              pin_alt_sel_i,
  output logic              line6_no,
  output logic              line7_no,
  output logic              shared6_o,
  output logic              shared7_o,
  output logic              pin_live_o
);
  localparam int unsigned HALF = N_KEY / 2;
  localparam logic [HALF-1:0] PIN6_BIT = HALF'(1) << PIN6_KEY;

  logic [N_KEY-1:0]  key_g;
  logic [N_WAKE-1:0] wake_g;
  logic              pin_sel;

  // masked sources read as idle-high
  assign key_g  = key_s_i | key_mask_i;
  assign wake_g = wake_s_i | wake_mask_i;

  assign line6_no  = &key_g[HALF-1:0];
  assign shared6_o = ~&(key_mask_i[HALF-1:0] | PIN6_BIT);

  // any upper-key or wake source in use cuts the pin off
  assign pin_live_o = (&key_mask_i[N_KEY-1:HALF]) & (&wake_mask_i);
  assign shared7_o  = ~pin_live_o;
  assign pin_sel    = pin_alt_sel_i ? pin_alt_s_i : pin_pri_s_i;
  assign line7_no   = (&key_g[N_KEY-1:HALF]) & (&wake_g) & (pin_sel | ~pin_live_o);
endmodule

// File: rtl/kic_chan.sv
module kic_chan
  import kic_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   line_ni,
  input  sense_e mode_i,
  input  logic   en_i,
  input  logic   shared_i,
  input  logic   clr_i,
  output logic   req_o
);
  logic prev_q, flag_q;
  logic fall, rise, hit;

  assign fall = prev_q & ~line_ni;
  assign rise = ~prev_q & line_ni;

  always_comb begin
    unique case (mode_i)
      SENSE_FALL: hit = fall;
      SENSE_RISE: hit = rise & ~shared_i;
      SENSE_BOTH: hit = (rise | fall) & ~shared_i;
      default:    hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      prev_q <= line_ni;
      if (en_i && hit)  flag_q <= 1'b1;
      else if (clr_i)   flag_q <= 1'b0;
    end
  end

  assign req_o = en_i & ((mode_i == SENSE_LOW) ? ~line_ni : flag_q);
endmodule

// File: rtl/key_irq_combiner.sv
module key_irq_combiner
  import kic_pkg::*;
#(
  parameter int unsigned N_KEY       = 16,
  parameter int unsigned N_WAKE      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PIN6_KEY    = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_KEY-1:0]  key_ni,
  input  logic [N_WAKE-1:0] wake_ni,
  input  logic              irq7_pri_ni,
  input  logic              irq7_alt_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [N_KEY-1:0]  reg_wdata_i,
  output logic              irq6_req_o,
  output logic              irq7_req_o
);
  localparam int unsigned SYNC_W = N_KEY + N_WAKE + 2;

  logic [SYNC_W-1:0] raw, synced;
  logic [N_KEY-1:0]  key_s, key_mask;
  logic [N_WAKE-1:0] wake_s, wake_mask;
  logic              pri_s, alt_s;
  ctrl_t             ctrl;
  logic              clr6, clr7;
  logic              line6_n, line7_n, shared6, shared7, pin_live;

  assign raw = {irq7_alt_ni, irq7_pri_ni, wake_ni, key_ni};

  kic_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(synced)
  );

  assign key_s  = synced[N_KEY-1:0];
  assign wake_s = synced[N_KEY +: N_WAKE];
  assign pri_s  = synced[N_KEY+N_WAKE];
  assign alt_s  = synced[N_KEY+N_WAKE+1];

  kic_regs #(.N_KEY(N_KEY), .N_WAKE(N_WAKE), .PIN6_KEY(PIN6_KEY)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .key_mask_o(key_mask), .wake_mask_o(wake_mask),
    .ctrl_o(ctrl), .clr6_o(clr6), .clr7_o(clr7)
  );

  kic_merge #(.N_KEY(N_KEY), .N_WAKE(N_WAKE), .PIN6_KEY(PIN6_KEY)) u_merge (
    .key_s_i(key_s), .wake_s_i(wake_s), .pin_pri_s_i(pri_s), .pin_alt_s_i(alt_s),
    .key_mask_i(key_mask), .wake_mask_i(wake_mask), .pin_alt_sel_i(ctrl.pin_alt),
    .line6_no(line6_n), .line7_no(line7_n), .shared6_o(shared6),
    .shared7_o(shared7), .pin_live_o(pin_live)
  );

  kic_chan u_ch6 (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_ni(line6_n), .mode_i(ctrl.mode6),
    .en_i(ctrl.en6), .shared_i(shared6), .clr_i(clr6), .req_o(irq6_req_o)
  );

  kic_chan u_ch7 (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_ni(line7_n), .mode_i(ctrl.mode7),
    .en_i(ctrl.en7), .shared_i(shared7), .clr_i(clr7), .req_o(irq7_req_o)
  );
endmodule

// File: rtl/key_irq_combiner_chk.sv
module key_irq_combiner_chk
  import kic_pkg::*;
#(
  parameter int unsigned N_KEY  = 16,
  parameter int unsigned N_WAKE = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [1:0]        reg_addr_i,
  input logic [N_KEY-1:0]  key_s_i,
  input logic [N_WAKE-1:0] wake_s_i,
  input logic [N_KEY-1:0]  key_mask_i,
  input logic [N_WAKE-1:0] wake_mask_i,
  input ctrl_t             ctrl_i,
  input logic              line7_ni,
  input logic              shared7_i,
  input logic              pin_live_i,
  input logic              irq6_req_o,
  input logic              irq7_req_o
);
  localparam int unsigned HALF = N_KEY / 2;

  logic rest7_idle;
  assign rest7_idle = (&(key_s_i[N_KEY-1:HALF] | key_mask_i[N_KEY-1:HALF]))
                    & (&(wake_s_i | wake_mask_i));

  // R4
  pin_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pin_live_i && rest7_idle) |-> line7_ni);

  // R10
  disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i.en6 |-> !irq6_req_o);

  // R11
  level_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.mode7 == SENSE_LOW && ctrl_i.en7) |-> (irq7_req_o == !line7_ni));

  // R7
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq6_req_o && ctrl_i.mode6 != SENSE_LOW &&
     !(reg_we_i && (reg_addr_i == A_CLEAR || reg_addr_i == A_CTRL))) |=> irq6_req_o);

  // R9
  shared_no_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shared7_i && (ctrl_i.mode7 == SENSE_RISE || ctrl_i.mode7 == SENSE_BOTH) &&
     !irq7_req_o && !reg_we_i) |=> !irq7_req_o);
endmodule

bind key_irq_combiner key_irq_combiner_chk #(.N_KEY(N_KEY), .N_WAKE(N_WAKE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .key_s_i(key_s), .wake_s_i(wake_s), .key_mask_i(key_mask), .wake_mask_i(wake_mask),
  .ctrl_i(ctrl), .line7_ni(line7_n), .shared7_i(shared7), .pin_live_i(pin_live),
  .irq6_req_o(irq6_req_o), .irq7_req_o(irq7_req_o)
);

// File: tb/key_irq_combiner_tb.sv
module key_irq_combiner_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] key_n = '1;
  logic [7:0]  wake_n = '1;
  logic        pri_n = 1'b1, alt_n = 1'b1;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        irq6, irq7;
  int          vectors = 0, fails = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  key_irq_combiner u_dut (
    .clk_i(clk), .rst_ni(rst_n), .key_ni(key_n), .wake_ni(wake_n),
    .irq7_pri_ni(pri_n), .irq7_alt_ni(alt_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .irq6_req_o(irq6), .irq7_req_o(irq7)
  );

  // ---------------- reference model built from the requirements
  logic [15:0] m_k1, m_k2, m_km;
  logic [7:0]  m_w1, m_w2, m_wm;
  logic [1:0]  m_p1, m_p2;
  logic [6:0]  m_ctrl;
  logic        m_prev6, m_prev7, m_f6, m_f7;

  function automatic logic f_line6();
    return &(m_k2[7:0] | m_km[7:0]);
  endfunction
  function automatic logic f_live();
    return (&m_km[15:8]) && (&m_wm);
  endfunction
  function automatic logic f_line7();
    logic pin;
    pin = m_ctrl[6] ? m_p2[1] : m_p2[0];
    return (&(m_k2[15:8] | m_km[15:8])) & (&(m_w2 | m_wm)) & (pin | !f_live());
  endfunction
  function automatic logic f_shared6();
    return !(&(m_km[7:0] | 8'h40));
  endfunction
  function automatic logic f_hit(logic [1:0] md, logic prev, logic line, logic sh);
    case (md)
      2'b01: return prev & !line;
      2'b10: return !prev & line & !sh;
      2'b11: return (prev ^ line) & !sh;
      default: return 1'b0;
    endcase
  endfunction
  function automatic logic f_req(logic [1:0] md, logic en, logic line, logic flag);
    return en & ((md == 2'b00) ? !line : flag);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_k1 <= '1; m_k2 <= '1; m_w1 <= '1; m_w2 <= '1; m_p1 <= '1; m_p2 <= '1;
      m_km <= 16'hFFBF; m_wm <= 8'hFF; m_ctrl <= '0;
      m_prev6 <= 1'b1; m_prev7 <= 1'b1; m_f6 <= 1'b0; m_f7 <= 1'b0;
    end else begin
      logic l6, l7;
      l6 = f_line6(); l7 = f_line7();
      if (m_ctrl[4] && f_hit(m_ctrl[1:0], m_prev6, l6, f_shared6())) m_f6 <= 1'b1;
      else if (we && addr == 2'd3 && wdata[0]) m_f6 <= 1'b0;
      if (m_ctrl[5] && f_hit(m_ctrl[3:2], m_prev7, l7, !f_live())) m_f7 <= 1'b1;
      else if (we && addr == 2'd3 && wdata[1]) m_f7 <= 1'b0;
      m_prev6 <= l6; m_prev7 <= l7;
      if (we) begin
        case (addr)
          2'd0: m_km <= wdata;
          2'd1: m_wm <= wdata[7:0];
          2'd2: m_ctrl <= wdata[6:0];
          default: ;
        endcase
      end
      m_k1 <= key_n; m_k2 <= m_k1; m_w1 <= wake_n; m_w2 <= m_w1;
      m_p1 <= {alt_n, pri_n}; m_p2 <= m_p1;
    end
  end

  // ---------------- helpers
  task automatic chk(string tag, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    we = 1'b1; addr = a; wdata = d;
    step(1);
    we = 1'b0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1 irq6 after reset", irq6, 1'b0);
    chk("R1 irq7 after reset", irq7, 1'b0);

    wr(2'd2, 16'h0030);                        // both enabled, low level
    key_n[6] = 1'b0; step(1);
    chk("R6 one edge not yet visible", irq6, 1'b0);
    step(1);
    chk("R1 key6 unmasked at reset / R11", irq6, 1'b1);
    key_n[6] = 1'b1; step(2);
    chk("R11 level release", irq6, 1'b0);
    key_n[5] = 1'b0; step(3);
    chk("R2 masked key ignored", irq6, 1'b0);
    key_n[5] = 1'b1;

    pri_n = 1'b0; step(2);
    chk("R5 primary pin", irq7, 1'b1);
    wr(2'd2, 16'h0070);
    chk("R5 alternate selected, idle", irq7, 1'b0);
    alt_n = 1'b0; step(2);
    chk("R5 alternate pin", irq7, 1'b1);
    alt_n = 1'b1; wr(2'd2, 16'h0030); step(2);
    chk("R5 back to primary", irq7, 1'b1);

    wr(2'd0, 16'hFEBF);
    chk("R4 pin cut by key mask", irq7, 1'b0);
    key_n[8] = 1'b0; step(2);
    chk("R3 upper key source", irq7, 1'b1);
    key_n[8] = 1'b1; step(2);
    wr(2'd0, 16'hFFBF);
    chk("R4 pin restored", irq7, 1'b1);
    wr(2'd1, 16'h00FE);
    chk("R4 pin cut by wake mask", irq7, 1'b0);
    wake_n[0] = 1'b0; step(2);
    chk("R3 wake source", irq7, 1'b1);
    wake_n[0] = 1'b1; wr(2'd1, 16'h00FF); pri_n = 1'b1; step(3);

    wr(2'd2, 16'h0031);                        // ch6 falling
    key_n[6] = 1'b0; step(2);
    chk("R6 edge needs one more cycle", irq6, 1'b0);
    step(1);
    chk("R7 falling edge latched", irq6, 1'b1);
    key_n[6] = 1'b1; step(4);
    chk("R7 flag held", irq6, 1'b1);
    wr(2'd3, 16'h0002);
    chk("R12 other clear bit ignored", irq6, 1'b1);
    wr(2'd3, 16'h0001);
    chk("R7 cleared", irq6, 1'b0);

    wr(2'd2, 16'h0032);                        // ch6 rising, unshared
    key_n[6] = 1'b0; step(4);
    chk("R8 fall ignored in rising mode", irq6, 1'b0);
    key_n[6] = 1'b1; step(3);
    chk("R8 rising edge latched", irq6, 1'b1);
    wr(2'd3, 16'h0001);

    wr(2'd0, 16'hFFBE);                        // key0 unmasked: ch6 shared
    key_n[0] = 1'b0; step(4); key_n[0] = 1'b1; step(4);
    chk("R9 shared rising blocked", irq6, 1'b0);
    wr(2'd2, 16'h0033);
    key_n[0] = 1'b0; step(4);
    chk("R9 shared both-edge blocked", irq6, 1'b0);
    wr(2'd2, 16'h0031);
    key_n[0] = 1'b1; step(4); key_n[0] = 1'b0; step(3);
    chk("R9 shared falling allowed", irq6, 1'b1);
    key_n[0] = 1'b1; step(4); wr(2'd3, 16'h0001);

    wr(2'd2, 16'h0001);                        // ch6 disabled, falling
    key_n[0] = 1'b0; step(4);
    chk("R10 disabled output low", irq6, 1'b0);
    wr(2'd2, 16'h0031);
    chk("R10 no edge latched while disabled", irq6, 1'b0);
    key_n[0] = 1'b1; step(4); wr(2'd0, 16'hFFBF);

    wr(2'd2, 16'h002C);                        // ch7 both edges, unshared
    pri_n = 1'b0; step(3);
    chk("R8 both-edge fall", irq7, 1'b1);
    wr(2'd3, 16'h0002);
    pri_n = 1'b1; step(3);
    chk("R8 both-edge rise", irq7, 1'b1);
    wr(2'd3, 16'h0002);
    chk("R7 ch7 clear", irq7, 1'b0);

    // constrained random against the model
    for (int i = 0; i < 4000; i++) begin
      chk("R2/R3/R7 random irq6", irq6,
          f_req(m_ctrl[1:0], m_ctrl[4], f_line6(), m_f6));
      chk("R3/R4/R9 random irq7", irq7,
          f_req(m_ctrl[3:2], m_ctrl[5], f_line7(), m_f7));
      if ($urandom_range(3) == 0) begin
        key_n  = ~(16'($urandom) & 16'($urandom) & 16'($urandom));
        wake_n = ~(8'($urandom) & 8'($urandom) & 8'($urandom));
        pri_n  = ($urandom_range(2) != 0);
        alt_n  = ($urandom_range(2) != 0);
      end
      we = ($urandom_range(7) == 0);
      addr = 2'($urandom);
      case (addr)
        2'd0: wdata = 16'($urandom) | 16'($urandom) | 16'($urandom);
        2'd1: wdata = 16'($urandom) | 16'($urandom) | 16'($urandom);
        default: wdata = 16'($urandom);
      endcase
      @(posedge clk); @(negedge clk);
    end
    we = 1'b0;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule